// File: doc/BRIEF.md
# Masked Vector Broadcast Unit

This unit fills a vector destination of 128, 256 or 512 bits by repeating an integer source. In the scalar form, one element of 8, 16, 32 or 64 bits is copied into every lane. In the sub-vector forms, a group of 2, 4 or 8 chunks is tiled across the destination, so that lane j takes chunk j mod P. Each lane can be gated by a writemask. A cleared mask bit either keeps the old destination lane (merging) or writes zeros (zeroing). Every bit above the chosen vector length is forced to zero.

An execution pipe presents one operation per `in_valid_i` pulse. The pulse carries the source, the old destination, the mask and the operation selects. One cycle later the unit returns a registered result with `valid_o`. Some combinations of length, pattern and operand kind are not allowed. For these, the unit raises `illegal_o` for one cycle instead of `valid_o`, and the result register keeps its previous contents.

Top module: `vbroadcast_unit`

## Requirements
- R1: While `rst_ni` is low, and after reset, `result_o` is all zeros and `valid_o` and `illegal_o` are 0.
- R2: After a cycle with `in_valid_i` high, exactly one of `valid_o` or `illegal_o` is high in the next cycle, for that one cycle only. Without `in_valid_i`, both stay low.
- R3: The vector-length select `vlen_i` is encoded 0=128, 1=256, 2=512 bits, and 3 is reserved. The element-size select `esize_i` is encoded 0=8, 1=16, 2=32, 3=64 bits. With the scalar pattern (`pattern_i`=0), each of the vlen/esize lanes receives the low element of `src_i`.
- R4: `pattern_i` is encoded as follows:
  - 1 = 2x32
  - 2 = 4x32
  - 3 = 2x64
  - 4 = 8x32
  - 5 = 4x64
  - 6 = 128-bit chunk repeated, unmasked, using 64-bit lanes with P=2
  - 7 = reserved

  Lane j (of width W) receives `src_i[(j mod P)*W +: W]`.
- R5: A lane takes the broadcast value when `mask_en_i` is 0 or when its mask bit `mask_i[j]` is 1.
- R6: A lane whose mask bit is 0 keeps the matching lane of `old_dst_i` when `zero_i` is 0, and becomes zero when `zero_i` is 1.
- R7: All result bits at or above the selected vector length are zero.
- R8: When `legacy_i` is 1, or when pattern 6 is used, no writemask applies. Every in-range lane is written, whatever `mask_en_i` and `mask_i` hold.
- R9: The following are illegal:
  - vlen 3
  - pattern 7
  - patterns 2, 3 or 6 at 128 bits
  - patterns 4 or 5 at any length other than 512
  - a legacy scalar 64-bit broadcast at 128 bits
- R10: Patterns 2 to 6 need a memory source. With `mem_src_i`=0, these patterns are illegal.
- R11: On an illegal operation, `illegal_o` pulses, `valid_o` stays low and `result_o` keeps its previous value.
- R12: Mask bits at positions at or above the active lane count have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation strobe |
| src_i | input | VEC_W | Source data; the element or chunks are taken from its low bits |
| old_dst_i | input | VEC_W | Previous destination value, used for merging |
| mask_i | input | VEC_W/8 | Per-lane writemask |
| mask_en_i | input | 1 | Writemask enable |
| zero_i | input | 1 | 1 = zeroing, 0 = merging for masked-off lanes |
| legacy_i | input | 1 | Unmasked legacy form |
| esize_i | input | 2 | Scalar element size select |
| pattern_i | input | 3 | Broadcast pattern select |
| vlen_i | input | 2 | Vector length select |
| mem_src_i | input | 1 | 1 = memory operand, 0 = register operand |
| result_o | output | VEC_W | Registered result |
| valid_o | output | 1 | Result strobe |
| illegal_o | output | 1 | Illegal-encoding strobe |

## Verification
The bench builds the unit with the default VEC_W of 512. This gives a 64-bit mask, which brings every vector length and every byte lane into reach, including the 8x32 and 4x64 patterns that exist only at full width. A behavioural model computes each byte of the expected result from the lane width, the pattern period, the mask and the length. The bench compares this model on every clock. It covers directed cases for each pattern, for merging and zeroing, and for every illegal combination, followed by a long run of random operations that are often issued back to back.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
  typedef enum logic [2:0] {
    PAT_SCALAR = 3'd0,
    PAT_2X32   = 3'd1,
    PAT_4X32   = 3'd2,
    PAT_2X64   = 3'd3,
    PAT_8X32   = 3'd4,
    PAT_4X64   = 3'd5,
    PAT_X128   = 3'd6,
    PAT_RSVD   = 3'd7
  } pat_e;

  typedef enum logic [1:0] {
    LEN_128  = 2'd0,
    LEN_256  = 2'd1,
    LEN_512  = 2'd2,
    LEN_RSVD = 2'd3
  } len_e;

  // lane width code: 0=8 1=16 2=32 3=64
  typedef struct packed {
    logic [1:0] wcode;
    logic [1:0] plog;
    logic       unmasked;
    logic       illegal;
  } dec_t;

  localparam int unsigned NUM_WIDTHS = 4;
  localparam int unsigned MIN_VL     = 128;
endpackage

// File: rtl/vbc_decode.sv
module vbc_decode
  import vbc_pkg::*;
(
  input  logic [2:0] pattern_i,
  input  logic [1:0] esize_i,
  input  logic [1:0] vlen_i,
  input  logic       legacy_i,
  input  logic       mask_en_i,
  input  logic       mem_src_i,
  output dec_t       dec_o
);
  pat_e pat;
  len_e len;
  logic need_mem;
  logic bad_len;

  assign pat = pat_e'(pattern_i);
  assign len = len_e'(vlen_i);

  always_comb begin
    dec_o.wcode = esize_i;
    dec_o.plog  = 2'd0;
    need_mem    = 1'b0;
    bad_len     = 1'b0;
    unique case (pat)
      PAT_SCALAR: begin
        dec_o.wcode = esize_i;
        dec_o.plog  = 2'd0;
        bad_len     = legacy_i && (esize_i == 2'd3) && (len == LEN_128);
      end
      PAT_2X32: begin
        dec_o.wcode = 2'd2;
        dec_o.plog  = 2'd1;
      end
      PAT_4X32: begin
        dec_o.wcode = 2'd2;
        dec_o.plog  = 2'd2;
        need_mem    = 1'b1;
        bad_len     = (len == LEN_128);
      end
      PAT_2X64: begin
        dec_o.wcode = 2'd3;
        dec_o.plog  = 2'd1;
        need_mem    = 1'b1;
        bad_len     = (len == LEN_128);
      end
      PAT_8X32: begin
        dec_o.wcode = 2'd2;
        dec_o.plog  = 2'd3;
        need_mem    = 1'b1;
        bad_len     = (len != LEN_512);
      end
      PAT_4X64: begin
        dec_o.wcode = 2'd3;
        dec_o.plog  = 2'd2;
        need_mem    = 1'b1;
        bad_len     = (len != LEN_512);
      end
      PAT_X128: begin
        dec_o.wcode = 2'd3;
        dec_o.plog  = 2'd1;
        need_mem    = 1'b1;
        bad_len     = (len == LEN_128);
      end
      default: begin
        dec_o.wcode = 2'd0;
        dec_o.plog  = 2'd0;
        bad_len     = 1'b1;
      end
    endcase
    dec_o.unmasked = legacy_i || !mask_en_i || (pat == PAT_X128);
    dec_o.illegal  = bad_len || (len == LEN_RSVD) || (need_mem && !mem_src_i);
  end
endmodule

// File: rtl/vbc_lane_array.sv
module vbc_lane_array
  import vbc_pkg::*;
#(
  parameter int unsigned VEC_W  = 512,
  parameter int unsigned ELEM_W = 32
) (
  input  logic [VEC_W-1:0]   src_i,
  input  logic [VEC_W-1:0]   old_i,
  input  logic [VEC_W/8-1:0] mask_i,
  input  logic               unmasked_i,
  input  logic               zero_i,
  input  logic [1:0]         plog_i,
  input  logic [1:0]         vlen_i,
  output logic [VEC_W-1:0]   out_o
);
  localparam int unsigned LANES      = VEC_W / ELEM_W;
  localparam int unsigned BASE_LANES = MIN_VL / ELEM_W;

  logic [7:0] act_lanes;
  logic [2:0] pmask;

  assign act_lanes = 8'(BASE_LANES) << vlen_i;
  assign pmask     = 3'((4'd1 << plog_i) - 4'd1);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [2:0] JLO = 3'(j % 8);
    logic [2:0]        sel;
    logic [ELEM_W-1:0] chunk;
    logic              active;
    logic              take;

    assign sel    = JLO & pmask;
    assign chunk  = src_i[sel*ELEM_W +: ELEM_W];
    assign active = 8'(j) < act_lanes;
    assign take   = unmasked_i || mask_i[j];

    always_comb begin
      if (!active)       out_o[j*ELEM_W +: ELEM_W] = '0;
      else if (take)     out_o[j*ELEM_W +: ELEM_W] = chunk;
      else if (zero_i)   out_o[j*ELEM_W +: ELEM_W] = '0;
      else               out_o[j*ELEM_W +: ELEM_W] = old_i[j*ELEM_W +: ELEM_W];
    end
  end
endmodule

// File: rtl/vbroadcast_unit.sv
module vbroadcast_unit
  import vbc_pkg::*;
#(
  parameter int unsigned VEC_W  = 512,
  localparam int unsigned MASK_W = VEC_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [VEC_W-1:0]  src_i,
  input  logic [VEC_W-1:0]  old_dst_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              mask_en_i,
  input  logic              zero_i,
  input  logic              legacy_i,
  input  logic [1:0]        esize_i,
  input  logic [2:0]        pattern_i,
  input  logic [1:0]        vlen_i,
  input  logic              mem_src_i,
  output logic [VEC_W-1:0]  result_o,
  output logic              valid_o,
  output logic              illegal_o
);
  dec_t             dec;
  logic [VEC_W-1:0] per_w [NUM_WIDTHS];
  logic [VEC_W-1:0] next_res;

  vbc_decode u_dec (
    .pattern_i (pattern_i),
    .esize_i   (esize_i),
    .vlen_i    (vlen_i),
    .legacy_i  (legacy_i),
    .mask_en_i (mask_en_i),
    .mem_src_i (mem_src_i),
    .dec_o     (dec)
  );

  for (genvar w = 0; w < NUM_WIDTHS; w++) begin : g_width
    vbc_lane_array #(
      .VEC_W  (VEC_W),
      .ELEM_W (8 << w)
    ) u_arr (
      .src_i      (src_i),
      .old_i      (old_dst_i),
      .mask_i     (mask_i),
      .unmasked_i (dec.unmasked),
      .zero_i     (zero_i),
      .plog_i     (dec.plog),
      .vlen_i     (vlen_i),
      .out_o      (per_w[w])
    );
  end

  assign next_res = per_w[dec.wcode];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      if (in_valid_i) begin
        if (dec.illegal) begin
          illegal_o <= 1'b1;
        end else begin
          valid_o  <= 1'b1;
          result_o <= next_res;
        end
      end
    end
  end
endmodule

// File: rtl/vbc_checker.sv
module vbc_checker #(
  parameter int unsigned VEC_W = 512
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [2:0]       pattern_i,
  input logic [1:0]       vlen_i,
  input logic             mem_src_i,
  input logic [VEC_W-1:0] result_o,
  input logic             valid_o,
  input logic             illegal_o
);
  assert_one_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && illegal_o));

  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !valid_o && !illegal_o);

  assert_hold_on_illegal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $stable(result_o));

  assert_upper_zero_128_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && vlen_i == 2'd0 |=> !valid_o || result_o[VEC_W-1:128] == '0);

  assert_upper_zero_256_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && vlen_i == 2'd1 |=> !valid_o || result_o[VEC_W-1:256] == '0);

  assert_full_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && (pattern_i == 3'd4 || pattern_i == 3'd5) && vlen_i != 2'd2 |=> illegal_o);

  assert_reg_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !mem_src_i && pattern_i >= 3'd2 && pattern_i <= 3'd6 |=> illegal_o);
endmodule

bind vbroadcast_unit vbc_checker #(.VEC_W(VEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .pattern_i  (pattern_i),
  .vlen_i     (vlen_i),
  .mem_src_i  (mem_src_i),
  .result_o   (result_o),
  .valid_o    (valid_o),
  .illegal_o  (illegal_o)
);

// File: tb/vbroadcast_unit_tb.sv
module vbroadcast_unit_tb;
  localparam int VEC_W = 512;
  localparam int MASK_W = VEC_W / 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid_i = 1'b0;
  logic [VEC_W-1:0]  src_i = '0;
  logic [VEC_W-1:0]  old_dst_i = '0;
  logic [MASK_W-1:0] mask_i = '0;
  logic              mask_en_i = 1'b0;
  logic              zero_i = 1'b0;
  logic              legacy_i = 1'b0;
  logic [1:0]        esize_i = '0;
  logic [2:0]        pattern_i = '0;
  logic [1:0]        vlen_i = '0;
  logic              mem_src_i = 1'b0;
  logic [VEC_W-1:0]  result_o;
  logic              valid_o;
  logic              illegal_o;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    checking = 1'b0;
  bit    done = 1'b0;

  logic [VEC_W-1:0] exp_res;
  logic             exp_valid;
  logic             exp_ill;

  always #4 clk_i = ~clk_i;

  vbroadcast_unit #(.VEC_W(VEC_W)) u_dut (.*);

  function automatic bit ref_illegal(int pat, int esz, int vl, bit leg, bit mem);
    if (vl == 3 || pat == 7) return 1;
    if (pat >= 2 && pat <= 6 && !mem) return 1;
    if (vl == 0 && (pat == 2 || pat == 3 || pat == 6)) return 1;
    if ((pat == 4 || pat == 5) && vl != 2) return 1;
    if (leg && pat == 0 && esz == 3 && vl == 0) return 1;
    return 0;
  endfunction

  function automatic logic [VEC_W-1:0] ref_result(
      int pat, int esz, int vl, bit leg, bit men, bit zr,
      logic [MASK_W-1:0] m, logic [VEC_W-1:0] s, logic [VEC_W-1:0] od);
    logic [VEC_W-1:0] r;
    int wb, per, vbytes, j, pos, ch;
    bit nomask;
    case (pat)
      0: begin wb = 1 << esz; per = 1; end
      1: begin wb = 4; per = 2; end
      2: begin wb = 4; per = 4; end
      3: begin wb = 8; per = 2; end
      4: begin wb = 4; per = 8; end
      5: begin wb = 8; per = 4; end
      default: begin wb = 8; per = 2; end
    endcase
    nomask = leg || !men || pat == 6;
    vbytes = 16 << vl;
    r = '0;
    for (int b = 0; b < VEC_W / 8; b++) begin
      j = b / wb;
      pos = b % wb;
      ch = j % per;
      if (b >= vbytes) r[b*8 +: 8] = 8'h00;
      else if (nomask || m[j]) r[b*8 +: 8] = s[(ch*wb + pos)*8 +: 8];
      else if (zr) r[b*8 +: 8] = 8'h00;
      else r[b*8 +: 8] = od[b*8 +: 8];
    end
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_res <= '0; exp_valid <= 1'b0; exp_ill <= 1'b0;
    end else begin
      exp_valid <= 1'b0; exp_ill <= 1'b0;
      if (in_valid_i) begin
        if (ref_illegal(pattern_i, esize_i, vlen_i, legacy_i, mem_src_i)) exp_ill <= 1'b1;
        else begin
          exp_valid <= 1'b1;
          exp_res <= ref_result(pattern_i, esize_i, vlen_i, legacy_i, mask_en_i, zero_i,
                                mask_i, src_i, old_dst_i);
        end
      end
    end
  end

  task automatic check(string req, string what, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (checking && !done) begin
      check(cur_req, "valid_o", VEC_W'(valid_o), VEC_W'(exp_valid));
      check(cur_req, "illegal_o", VEC_W'(illegal_o), VEC_W'(exp_ill));
      check(cur_req, "result_o", result_o, exp_res);
    end
  end

  function automatic logic [VEC_W-1:0] rnd_vec();
    logic [VEC_W-1:0] v;
    for (int k = 0; k < VEC_W / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic op(int pat, int esz, int vl, bit leg, bit mem, bit men, bit zr,
                    logic [MASK_W-1:0] m);
    @(negedge clk_i);
    pattern_i = 3'(pat); esize_i = 2'(esz); vlen_i = 2'(vl);
    legacy_i = leg; mem_src_i = mem; mask_en_i = men; zero_i = zr;
    mask_i = m; src_i = rnd_vec(); old_dst_i = rnd_vec();
    in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    checking = 1'b1;
    cur_req = "R1";
    repeat (3) @(negedge clk_i);
    check("R1", "reset result", result_o, '0);
    check("R1", "reset valid", VEC_W'(valid_o), '0);
    rst_ni = 1'b1;
    idle(2);

    cur_req = "R3";
    for (int e = 0; e < 4; e++)
      for (int v = 0; v < 3; v++) op(0, e, v, 0, 0, 0, 0, '0);

    cur_req = "R4";
    for (int p = 1; p < 7; p++) op(p, 0, 2, 0, 1, 0, 0, '0);
    op(1, 0, 0, 0, 0, 0, 0, '0);

    cur_req = "R5";
    op(0, 0, 2, 0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    op(2, 0, 2, 0, 1, 1, 0, 64'h0000_0000_0000_A5C3);

    cur_req = "R6";
    op(0, 1, 2, 0, 0, 1, 0, 64'h0000_0000_5555_5555);
    op(0, 1, 2, 0, 0, 1, 1, 64'h0000_0000_5555_5555);
    op(5, 0, 2, 0, 1, 1, 1, 64'h0000_0000_0000_0069);

    cur_req = "R7";
    op(0, 2, 0, 0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFF0);
    op(3, 0, 1, 0, 1, 1, 0, 64'h0000_0000_0000_0005);

    cur_req = "R8";
    op(0, 0, 1, 1, 0, 1, 1, '0);
    op(6, 0, 2, 0, 1, 1, 1, '0);

    cur_req = "R12";
    op(0, 0, 0, 0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_0000);
    op(0, 3, 1, 0, 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFF0);

    cur_req = "R9";
    op(0, 0, 3, 0, 0, 0, 0, '0);
    op(7, 0, 2, 0, 1, 0, 0, '0);
    op(2, 0, 0, 0, 1, 1, 0, '1);
    op(3, 0, 0, 0, 1, 1, 0, '1);
    op(6, 0, 0, 0, 1, 0, 0, '0);
    op(4, 0, 1, 0, 1, 0, 0, '0);
    op(5, 0, 0, 0, 1, 0, 0, '0);
    op(0, 3, 0, 1, 0, 0, 0, '0);
    op(0, 3, 0, 0, 0, 1, 0, '1);

    cur_req = "R10";
    for (int p = 2; p < 7; p++) op(p, 0, 2, 0, 0, 0, 0, '0);

    cur_req = "R11";
    op(0, 0, 2, 0, 0, 0, 0, '0);
    op(4, 0, 2, 0, 0, 0, 0, '0);
    idle(1);

    cur_req = "R2";
    idle(4);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      pattern_i = 3'($urandom); esize_i = 2'($urandom); vlen_i = 2'($urandom);
      legacy_i = 1'($urandom); mem_src_i = ($urandom % 4) != 0;
      mask_en_i = 1'($urandom); zero_i = 1'($urandom);
      mask_i = {$urandom, $urandom}; src_i = rnd_vec(); old_dst_i = rnd_vec();
      in_valid_i = ($urandom % 4) != 0;
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    idle(3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule